// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps a wall-clock calendar (seconds, minutes, hours, weekday, day of month, month and a two-digit year) in BCD and advances it by one second on every cycle in which the tick input is high. The host loads a new time by writing the seven field registers, which only fill a staging copy. It then sets the flag bit of the time update register, and the whole staged set replaces the running time in one cycle. Whether February has 29 days is not computed. It follows a leap flag that the host writes in the top bit of the year register.

An alarm is staged and committed the same way. Each alarm field carries its own enable bit, and only enabled fields are compared. When the running time starts to match, a sticky status bit is set. The host clears it by writing a one. The interrupt output is the status bit gated by an enable bit. The calendar always runs in 24-hour form.

Register map (5-bit address, 16-bit data, flag bit is bit 15): 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year (bit 15 leap), 7 time update, 8 to 14 alarm fields in the same order (bit 15 field enable), 15 alarm update, 16 control, 17 interrupt enable (bit 0), 18 interrupt status (bit 0). Field values sit in the low bits in BCD. Other addresses read as zero.

Top module: `bcd_rtc_alarm`

## Requirements
- R1: After reset the running time reads 00:00:00, weekday 0, day 01, month 01, year 00 with the leap flag clear. Interrupt enable, status, alarm values and alarm enables read 0, and irq_o is low.
- R2: Writes to addresses 0 to 6 leave the running time unchanged until a commit. Reads of addresses 0 to 6 return the running time, with the leap flag in bit 15 of address 6.
- R3: Writing address 7 with bit 15 set makes bit 15 of address 7 read 1 for one cycle. On the next clock the running time takes all staged fields at once and the bit reads 0 again. A commit takes priority over a tick in the same cycle.
- R4: On each cycle with tick_i high, seconds count in BCD and wrap from 59 to 00 with a carry into minutes. Minutes wrap from 59 to 00 with a carry into hours, and hours wrap from 23 to 00.
- R5: At the hour wrap the weekday advances and goes from 6 to 0. The day advances and goes back to 01 after the last day of the month. Month 12 goes to 01, and year 99 goes to 00.
- R6: February has 29 days when the leap flag is 1 and 28 when it is 0. The flag keeps its value as the calendar advances.
- R7: April, June, September and November end at day 30, and the other months except February end at day 31.
- R8: Writes to addresses 8 to 14 (value in the low bits, enable in bit 15) are staged. Writing address 15 with bit 15 set commits them on the next clock. Reads of 8 to 14 return the committed alarm. Only enabled fields are compared, and with no field enabled the alarm never matches.
- R9: Status bit 0 (address 18) is set on the tick after which the running time matches the alarm while it did not match before. It is not set again while that match persists.
- R10: Status is sticky. Writing 1 to bit 0 of address 18 clears it, and writing 0 has no effect.
- R11: irq_o is high exactly when status bit 0 and enable bit 0 (address 17) are both 1.
- R12: Bit 0 of the control register (address 16) reads 1 for 24-hour mode, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data (combinational on addr_i) |
| tick_i | input | 1 | One-second advance pulse, one clock wide |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The calendar is started from several loaded times. One is the full end-of-century carry at 23:59:59 on day 31, month 12, year 99 with weekday 6. Others are February 28 and 29 with the leap flag set and with it clear, a 30-day month end, a 31-day month passing day 30, and a plain minute carry. Together these separate each carry stage and the month-length choice. The alarm is tried with only seconds enabled while another field holds a value that does not match, with only minutes enabled so that the match lasts many ticks, and with no field enabled. These show the per-field enable, the start-of-match edge and the empty-mask case. A commit that lands on the same cycle as a tick tells the load priority apart from advancing.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;
  localparam int unsigned NUM_FIELDS = 7;
  localparam int unsigned REG_W      = 16;
  localparam int unsigned FLAG_BIT   = REG_W - 1;

  localparam int unsigned A_TIME_UPD = 7;
  localparam int unsigned A_ALM_BASE = 8;
  localparam int unsigned A_ALM_UPD  = A_ALM_BASE + NUM_FIELDS;
  localparam int unsigned A_CTRL     = 16;
  localparam int unsigned A_IEN      = 17;
  localparam int unsigned A_STS      = 18;

  typedef struct packed {
    logic       leap;
    logic [7:0] year;
    logic [4:0] mon;
    logic [5:0] day;
    logic [2:0] wday;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } cal_t;

  localparam cal_t CAL_RESET = '{leap: 1'b0, year: 8'h00, mon: 5'h01, day: 6'h01,
                                 wday: 3'd0, hour: 6'h00, min: 7'h00, sec: 7'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // last day of a BCD month
  function automatic logic [5:0] month_len(input logic [4:0] m, input logic leap);
    case (m)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] cal_get(input cal_t c, input logic [2:0] idx);
    logic [REG_W-1:0] r;
    r = '0;
    case (idx)
      3'd0: r[6:0] = c.sec;
      3'd1: r[6:0] = c.min;
      3'd2: r[5:0] = c.hour;
      3'd3: r[2:0] = c.wday;
      3'd4: r[5:0] = c.day;
      3'd5: r[4:0] = c.mon;
      3'd6: begin r[7:0] = c.year; r[FLAG_BIT] = c.leap; end
      default: ;
    endcase
    return r;
  endfunction

  function automatic cal_t cal_set(input cal_t c, input logic [2:0] idx,
                                   input logic [REG_W-1:0] d);
    cal_t r;
    r = c;
    case (idx)
      3'd0: r.sec  = d[6:0];
      3'd1: r.min  = d[6:0];
      3'd2: r.hour = d[5:0];
      3'd3: r.wday = d[2:0];
      3'd4: r.day  = d[5:0];
      3'd5: r.mon  = d[4:0];
      3'd6: begin r.year = d[7:0]; r.leap = d[FLAG_BIT]; end
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bcd_rtc_time_core.sv
module bcd_rtc_time_core
  import bcd_rtc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic load_i,
  input  cal_t load_val_i,
  output cal_t time_o,
  output cal_t next_o
);
  cal_t cur_q, nxt;
  logic wrap_s, wrap_m, wrap_h, wrap_d, wrap_mo;
  logic [7:0] inc_s, inc_m, inc_h, inc_d, inc_mo, inc_y;

  assign inc_s  = bcd_inc({1'b0, cur_q.sec});
  assign inc_m  = bcd_inc({1'b0, cur_q.min});
  assign inc_h  = bcd_inc({2'b0, cur_q.hour});
  assign inc_d  = bcd_inc({2'b0, cur_q.day});
  assign inc_mo = bcd_inc({3'b0, cur_q.mon});
  assign inc_y  = bcd_inc(cur_q.year);

  // carry chain; >= keeps out-of-range loads from running away
  assign wrap_s  = cur_q.sec >= 7'h59;
  assign wrap_m  = wrap_s && cur_q.min >= 7'h59;
  assign wrap_h  = wrap_m && cur_q.hour >= 6'h23;
  assign wrap_d  = wrap_h && cur_q.day >= month_len(cur_q.mon, cur_q.leap);
  assign wrap_mo = wrap_d && cur_q.mon >= 5'h12;

  always_comb begin
    nxt     = cur_q;
    nxt.sec = wrap_s ? 7'h00 : inc_s[6:0];
    if (wrap_s) nxt.min  = wrap_m ? 7'h00 : inc_m[6:0];
    if (wrap_m) nxt.hour = wrap_h ? 6'h00 : inc_h[5:0];
    if (wrap_h) begin
      nxt.wday = (cur_q.wday >= 3'd6) ? 3'd0 : cur_q.wday + 3'd1;
      nxt.day  = wrap_d ? 6'h01 : inc_d[5:0];
    end
    if (wrap_d)  nxt.mon  = wrap_mo ? 5'h01 : inc_mo[4:0];
    if (wrap_mo) nxt.year = (cur_q.year >= 8'h99) ? 8'h00 : inc_y;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cur_q <= CAL_RESET;
    else if (load_i) cur_q <= load_val_i;
    else if (tick_i) cur_q <= nxt;
  end

  assign time_o = cur_q;
  assign next_o = nxt;
endmodule

// File: rtl/bcd_rtc_match.sv
module bcd_rtc_match
  import bcd_rtc_pkg::*;
(
  input  cal_t                  now_i,
  input  cal_t                  alm_i,
  input  logic [NUM_FIELDS-1:0] en_i,
  output logic                  hit_o
);
  logic [NUM_FIELDS-1:0] eq;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    logic [REG_W-1:0] a, b;
    assign a     = cal_get(now_i, 3'(i));
    assign b     = cal_get(alm_i, 3'(i));
    assign eq[i] = !en_i[i] || (a[FLAG_BIT-1:0] == b[FLAG_BIT-1:0]);
  end

  assign hit_o = (|en_i) && (&eq);
endmodule

// File: rtl/bcd_rtc_alarm.sv
module bcd_rtc_alarm
  import bcd_rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              tick_i,
  output logic              irq_o
);
  cal_t stage_time, stage_alm, alm_q, cur_time, nxt_time;
  logic [NUM_FIELDS-1:0] stage_en, alm_en_q;
  logic time_trig_q, alm_trig_q, ien_q, sts_q;
  logic hit_cur, hit_nxt, sts_set;
  logic [2:0] idx;
  logic wr_time, wr_tupd, wr_alm, wr_aupd, wr_ien, wr_sts;
  logic [REG_W-1:0] alm_rd;

  assign idx     = addr_i[2:0];
  assign wr_time = we_i && addr_i < ADDR_W'(NUM_FIELDS);
  assign wr_tupd = we_i && addr_i == ADDR_W'(A_TIME_UPD);
  assign wr_alm  = we_i && addr_i >= ADDR_W'(A_ALM_BASE) && addr_i < ADDR_W'(A_ALM_UPD);
  assign wr_aupd = we_i && addr_i == ADDR_W'(A_ALM_UPD);
  assign wr_ien  = we_i && addr_i == ADDR_W'(A_IEN);
  assign wr_sts  = we_i && addr_i == ADDR_W'(A_STS);

  bcd_rtc_time_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (time_trig_q),
    .load_val_i (stage_time),
    .time_o     (cur_time),
    .next_o     (nxt_time)
  );

  bcd_rtc_match u_match_cur (.now_i(cur_time), .alm_i(alm_q), .en_i(alm_en_q), .hit_o(hit_cur));
  bcd_rtc_match u_match_nxt (.now_i(nxt_time), .alm_i(alm_q), .en_i(alm_en_q), .hit_o(hit_nxt));

  // status rises only at the start of a match
  assign sts_set = tick_i && !time_trig_q && hit_nxt && !hit_cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_time  <= CAL_RESET;
      stage_alm   <= '0;
      stage_en    <= '0;
      alm_q       <= '0;
      alm_en_q    <= '0;
      time_trig_q <= 1'b0;
      alm_trig_q  <= 1'b0;
      ien_q       <= 1'b0;
      sts_q       <= 1'b0;
    end else begin
      time_trig_q <= wr_tupd && wdata_i[FLAG_BIT];
      alm_trig_q  <= wr_aupd && wdata_i[FLAG_BIT];
      if (wr_time) stage_time <= cal_set(stage_time, idx, wdata_i);
      if (wr_alm) begin
        stage_alm     <= cal_set(stage_alm, idx, wdata_i);
        stage_en[idx] <= wdata_i[FLAG_BIT];
      end
      if (alm_trig_q) begin
        alm_q    <= stage_alm;
        alm_en_q <= stage_en;
      end
      if (wr_ien) ien_q <= wdata_i[0];
      if (sts_set)                  sts_q <= 1'b1;
      else if (wr_sts && wdata_i[0]) sts_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    alm_rd  = cal_get(alm_q, idx);
    if (addr_i < ADDR_W'(NUM_FIELDS)) rdata_o = cal_get(cur_time, idx);
    else if (addr_i == ADDR_W'(A_TIME_UPD)) rdata_o[FLAG_BIT] = time_trig_q;
    else if (addr_i >= ADDR_W'(A_ALM_BASE) && addr_i < ADDR_W'(A_ALM_UPD))
      rdata_o = {alm_en_q[idx], alm_rd[FLAG_BIT-1:0]};
    else if (addr_i == ADDR_W'(A_ALM_UPD)) rdata_o[FLAG_BIT] = alm_trig_q;
    else if (addr_i == ADDR_W'(A_CTRL))    rdata_o[0] = 1'b1;
    else if (addr_i == ADDR_W'(A_IEN))     rdata_o[0] = ien_q;
    else if (addr_i == ADDR_W'(A_STS))     rdata_o[0] = sts_q;
  end

  assign irq_o = sts_q && ien_q;
endmodule

// File: rtl/bcd_rtc_alarm_chk.sv
module bcd_rtc_alarm_chk
  import bcd_rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  we_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [REG_W-1:0]      wdata_i,
  input logic                  tick_i,
  input logic                  irq_o,
  input cal_t                  cur_time,
  input logic                  time_trig_q,
  input logic                  sts_q,
  input logic                  ien_q,
  input logic [NUM_FIELDS-1:0] alm_en_q
);
  logic re_trig, sts_clr;
  assign re_trig = we_i && addr_i == ADDR_W'(A_TIME_UPD) && wdata_i[FLAG_BIT];
  assign sts_clr = we_i && addr_i == ADDR_W'(A_STS) && wdata_i[0];

  a_r3_trig_self_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_trig_q && !re_trig |=> !time_trig_q);

  a_r2_time_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !time_trig_q |=> $stable(cur_time));

  a_r4_sec_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !time_trig_q && cur_time.sec == 7'h59 |=> cur_time.sec == 7'h00);

  a_r10_sts_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_q && !sts_clr |=> sts_q);

  a_r11_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien_q |-> !irq_o);

  a_r8_no_enable_no_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alm_en_q == '0 && !sts_q |=> !sts_q);

  a_r9_status_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !$rose(sts_q));
endmodule

bind bcd_rtc_alarm bcd_rtc_alarm_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .tick_i      (tick_i),
  .irq_o       (irq_o),
  .cur_time    (cur_time),
  .time_trig_q (time_trig_q),
  .sts_q       (sts_q),
  .ien_q       (ien_q),
  .alm_en_q    (alm_en_q)
);

// File: tb/sim_bcd_rtc_alarm.sv
module sim_bcd_rtc_alarm;
  typedef logic [6:0][15:0] regs_t;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, tick = 1'b0;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic irq;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcd_rtc_alarm u0 (.clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
                    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .irq_o(irq));

  function automatic regs_t tm(input logic [15:0] s, mi, h, wd, d, mo, y);
    regs_t r;
    r[0] = s; r[1] = mi; r[2] = h; r[3] = wd; r[4] = d; r[5] = mo; r[6] = y;
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rd_check(input string req, input logic [4:0] a, input logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic set_time(input regs_t v);
    for (int i = 0; i < 7; i++) wr(5'(i), v[i]);
    wr(5'd7, 16'h8000);
    @(negedge clk);
  endtask

  task automatic set_alarm(input regs_t v);
    for (int i = 0; i < 7; i++) wr(5'(8 + i), v[i]);
    wr(5'd15, 16'h8000);
    @(negedge clk);
  endtask

  task automatic check_time(input string req, input regs_t exp);
    for (int i = 0; i < 7; i++) rd_check(req, 5'(i), exp[i]);
  endtask

  task automatic t_reset();
    check_time("R1 reset time", tm(0, 0, 0, 0, 16'h01, 16'h01, 0));
    rd_check("R1 ien", 5'd17, 16'h0000);
    rd_check("R1 sts", 5'd18, 16'h0000);
    rd_check("R1 alarm", 5'd8, 16'h0000);
    check("R1 irq", {15'b0, irq}, 16'h0000);
    rd_check("R12 ctrl 24h", 5'd16, 16'h0001);
    wr(5'd16, 16'h0000);
    rd_check("R12 ctrl write ignored", 5'd16, 16'h0001);
  endtask

  task automatic t_stage_commit();
    wr(5'd0, 16'h0030);
    wr(5'd2, 16'h0011);
    rd_check("R2 staged not visible", 5'd0, 16'h0000);
    rd_check("R2 staged hour not visible", 5'd2, 16'h0000);
    wr(5'd7, 16'h8000);
    rd_check("R3 trigger pending", 5'd7, 16'h8000);
    @(negedge clk);
    rd_check("R3 trigger self-cleared", 5'd7, 16'h0000);
    rd_check("R3 sec committed", 5'd0, 16'h0030);
    rd_check("R3 hour committed", 5'd2, 16'h0011);
    // commit coincides with tick: load wins
    wr(5'd0, 16'h0045);
    wr(5'd7, 16'h8000);
    tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    rd_check("R3 commit beats tick", 5'd0, 16'h0045);
  endtask

  task automatic t_rollover();
    set_time(tm(16'h58, 16'h59, 16'h10, 2, 16'h15, 16'h06, 16'h42));
    do_tick();
    check_time("R4 plain second", tm(16'h59, 16'h59, 16'h10, 2, 16'h15, 16'h06, 16'h42));
    do_tick();
    check_time("R4 hour carry", tm(0, 0, 16'h11, 2, 16'h15, 16'h06, 16'h42));
    set_time(tm(16'h59, 16'h59, 16'h23, 6, 16'h31, 16'h12, 16'h99));
    do_tick();
    check_time("R5 century carry", tm(0, 0, 0, 0, 16'h01, 16'h01, 16'h00));
  endtask

  task automatic t_months();
    set_time(tm(16'h59, 16'h59, 16'h23, 1, 16'h28, 16'h02, 16'h23));
    do_tick();
    rd_check("R6 feb28 no leap day", 5'd4, 16'h0001);
    rd_check("R6 feb28 no leap month", 5'd5, 16'h0003);
    set_time(tm(16'h59, 16'h59, 16'h23, 1, 16'h28, 16'h02, 16'h8024));
    do_tick();
    rd_check("R6 feb28 leap day", 5'd4, 16'h0029);
    rd_check("R6 feb28 leap month", 5'd5, 16'h0002);
    rd_check("R6 leap flag kept", 5'd6, 16'h8024);
    set_time(tm(16'h59, 16'h59, 16'h23, 2, 16'h29, 16'h02, 16'h8024));
    do_tick();
    rd_check("R6 feb29 day", 5'd4, 16'h0001);
    rd_check("R6 feb29 month", 5'd5, 16'h0003);
    set_time(tm(16'h59, 16'h59, 16'h23, 3, 16'h30, 16'h04, 16'h10));
    do_tick();
    rd_check("R7 apr30 day", 5'd4, 16'h0001);
    rd_check("R7 apr30 month", 5'd5, 16'h0005);
    set_time(tm(16'h59, 16'h59, 16'h23, 3, 16'h30, 16'h01, 16'h10));
    do_tick();
    rd_check("R7 jan30 day", 5'd4, 16'h0031);
    rd_check("R7 jan30 month", 5'd5, 16'h0001);
  endtask

  task automatic t_alarm_sec();
    set_alarm(tm(16'h8005, 16'h0040, 0, 0, 0, 0, 0));
    rd_check("R8 alarm sec readback", 5'd8, 16'h8005);
    rd_check("R8 alarm min readback", 5'd9, 16'h0040);
    wr(5'd8, 16'h8007);
    rd_check("R8 alarm staged not visible", 5'd8, 16'h8005);
    wr(5'd8, 16'h8005);
    wr(5'd17, 16'h0001);
    set_time(tm(16'h03, 0, 0, 0, 16'h01, 16'h01, 0));
    do_tick();
    rd_check("R9 no status before match", 5'd18, 16'h0000);
    check("R11 irq low before match", {15'b0, irq}, 16'h0000);
    do_tick();
    rd_check("R9 status at match (R8 min disabled)", 5'd18, 16'h0001);
    check("R11 irq high", {15'b0, irq}, 16'h0001);
    do_tick();
    rd_check("R10 status sticky", 5'd18, 16'h0001);
    wr(5'd18, 16'h0000);
    rd_check("R10 write 0 no effect", 5'd18, 16'h0001);
    wr(5'd18, 16'h0001);
    rd_check("R10 write 1 clears", 5'd18, 16'h0000);
    check("R11 irq low after clear", {15'b0, irq}, 16'h0000);
    wr(5'd17, 16'h0000);
    set_time(tm(16'h04, 0, 0, 0, 16'h01, 16'h01, 0));
    do_tick();
    rd_check("R11 status set with irq disabled", 5'd18, 16'h0001);
    check("R11 irq gated off", {15'b0, irq}, 16'h0000);
    wr(5'd18, 16'h0001);
  endtask

  task automatic t_alarm_persist();
    set_alarm(tm(0, 16'h8001, 0, 0, 0, 0, 0));
    set_time(tm(16'h58, 0, 0, 0, 16'h01, 16'h01, 0));
    do_tick();
    rd_check("R9 minute alarm not yet", 5'd18, 16'h0000);
    do_tick();
    rd_check("R9 minute alarm start", 5'd18, 16'h0001);
    wr(5'd18, 16'h0001);
    do_tick();
    rd_check("R9 no re-set while match persists", 5'd18, 16'h0000);
  endtask

  task automatic t_alarm_none();
    set_alarm(tm(16'h0005, 0, 0, 0, 16'h01, 16'h01, 0));
    set_time(tm(16'h03, 0, 0, 0, 16'h01, 16'h01, 0));
    do_tick(); do_tick(); do_tick();
    rd_check("R8 no enabled field never matches", 5'd18, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stage_commit();
    t_rollover();
    t_months();
    t_alarm_sec();
    t_alarm_persist();
    t_alarm_none();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule